// File: doc/BRIEF.md
# Packet Receive Handler with Filtering

This block sits behind a preamble and sync-word detector in a radio receiver. When a one-cycle sync-found pulse marks the start of a packet, it takes the following received bytes one at a time. It writes the packet content into an external receive FIFO through a simple write port. It also strips and checks an optional trailing CRC, and it raises a payload-ready flag once a complete, accepted packet sits in the FIFO.

Two packet formats are supported. In the fixed format the body length comes from configuration. In the variable format the first byte after sync carries the length, and that length is bounded by the same configuration value, which then acts as a maximum. An optional node-address filter compares the first body byte against a configured address. Packets that are rejected are flushed from the FIFO with a one-cycle clear pulse. Packets whose CRC fails are flushed the same way, unless the flush is overridden by configuration.

Top module: `pkt_rx_filter`

## Requirements
- R1: While reset is held and on the first cycle after it, fifoWrEn, fifoClear, payloadReady and crcOk are all 0.
- R2: In fixed format (cfgVarLen=0), after syncFound exactly cfgPayloadLen bytes are written to the FIFO in arrival order. Each write appears on fifoWrEn/fifoWrData in the cycle after the byte is presented with rxValid=1. Cycles with rxValid=0 are skipped.
- R3: In variable format (cfgVarLen=1), the first byte after syncFound is the length L. That byte is written to the FIFO, followed by exactly L further bytes. L=0 gives an empty body.
- R4: In variable format a length byte greater than cfgPayloadLen discards the packet. Nothing of it stays in the FIFO, fifoClear pulses, payloadReady stays 0, and the block waits for the next syncFound. A length equal to cfgPayloadLen is accepted. fifoWrEn and fifoClear are never high together.
- R5: With cfgAddrEn=1 and a non-empty body, the address byte is the first body byte: the second byte in variable format and the first byte in fixed format. If it differs from cfgNodeAddr, it is not written, fifoClear pulses, and the rest of the packet is ignored until the next syncFound. A matching address byte is written like any payload byte.
- R6: With cfgCrcEn=1, two CRC bytes (high byte first) follow the body and are never written. The expected CRC is CRC-16 with polynomial 0x1021 and seed 0x1D0F, processed MSB first over every written byte, including the length and address bytes. crcOk goes to 1 when they match. crcOk returns to 0 at each accepted syncFound and stays 0 for packets received with cfgCrcEn=0.
- R7: On a CRC mismatch with cfgCrcAutoClearOff=0, fifoClear pulses and payloadReady does not rise.
- R8: On a CRC mismatch with cfgCrcAutoClearOff=1, the data stays in the FIFO, payloadReady rises and crcOk is 0.
- R9: For an accepted packet, payloadReady rises in the cycle after its final byte, which is the last body byte, or the second CRC byte when cfgCrcEn=1. It stays 1 until fifoEmpty is sampled at 1 on a later clock edge. If the rise and fifoEmpty=1 fall on the same edge, the rise wins.
- R10: A syncFound pulse that arrives while a packet is still being received is ignored. The byte presented with it is processed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncFound | input | 1 | One-cycle pulse: a packet starts with the next byte |
| rxValid | input | 1 | rxByte carries a received byte this cycle |
| rxByte | input | 8 | Received byte |
| cfgVarLen | input | 1 | 1 = variable format, 0 = fixed format |
| cfgPayloadLen | input | 8 | Fixed body length, or maximum length in variable format |
| cfgAddrEn | input | 1 | Enable node-address filtering |
| cfgNodeAddr | input | 8 | Node address compared against the address byte |
| cfgCrcEn | input | 1 | Expect and check two trailing CRC bytes |
| cfgCrcAutoClearOff | input | 1 | Keep data and flag ready despite a CRC mismatch |
| fifoEmpty | input | 1 | FIFO is empty; releases payloadReady |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoWrData | output | 8 | FIFO write data |
| fifoClear | output | 1 | One-cycle FIFO flush |
| payloadReady | output | 1 | A complete accepted packet is in the FIFO |
| crcOk | output | 1 | CRC of the last checked packet matched |

## Verification
The functions that can land on the same clock edge are the setting of payloadReady at packet completion and its release by fifoEmpty. A directed case holds fifoEmpty at 1 through a whole packet and samples payloadReady right after the final byte, where it must be 1, and again one cycle later, where it must be 0. A second overlap is a syncFound pulse sent together with a body byte mid-packet. Random packets provoke this often, and they are judged by comparing the FIFO image with the byte list the bench predicts from the length, address and CRC rules.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEN,
    ST_BODY,
    ST_CRC_HI,
    ST_CRC_LO
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic crcInit;
    logic crcUpd;
    logic cntLoadCfg;
    logic cntLoadByte;
    logic cntDec;
    logic wrByte;
    logic clrFifo;
    logic capHi;
    logic markReady;
    logic crcResValid;
  } dpCtrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic lenOk;
    logic byteZero;
    logic addrOk;
    logic cntOne;
    logic crcMatch;
  } dpStat_t;

endpackage

// File: rtl/pkt_rx_dp.sv
module pkt_rx_dp
  import pkt_rx_pkg::*;
#(
  parameter int          DATA_W   = BYTE_W,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_SEED = 16'h1D0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [DATA_W-1:0] cfgPayloadLen,
  input  logic [DATA_W-1:0] cfgNodeAddr,
  input  logic              fifoEmpty,
  output dpStat_t           stat,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] fifoWrData,
  output logic              fifoClear,
  output logic              payloadReady,
  output logic              crcOk
);

  localparam int CRC_W = 16;

  logic [DATA_W-1:0] cnt;
  logic [CRC_W-1:0]  crcReg;
  logic [DATA_W-1:0] crcHi;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c,
                                               input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  always_comb begin
    stat.lenOk    = (rxByte <= cfgPayloadLen);
    stat.byteZero = (rxByte == '0);
    stat.addrOk   = (rxByte == cfgNodeAddr);
    stat.cntOne   = (cnt == DATA_W'(1));
    stat.crcMatch = ({crcHi, rxByte} == crcReg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoWrEn     <= 1'b0;
      fifoWrData   <= '0;
      fifoClear    <= 1'b0;
      payloadReady <= 1'b0;
      crcOk        <= 1'b0;
      cnt          <= '0;
      crcReg       <= CRC_SEED;
      crcHi        <= '0;
    end else begin
      fifoWrEn  <= ctrl.wrByte;
      fifoClear <= ctrl.clrFifo;
      if (ctrl.wrByte) fifoWrData <= rxByte;

      if (ctrl.crcInit)     crcReg <= CRC_SEED;
      else if (ctrl.crcUpd) crcReg <= crcStep(crcReg, rxByte);

      if (ctrl.cntLoadCfg)       cnt <= cfgPayloadLen;
      else if (ctrl.cntLoadByte) cnt <= rxByte;
      else if (ctrl.cntDec)      cnt <= cnt - DATA_W'(1);

      if (ctrl.capHi) crcHi <= rxByte;

      // completion outranks the release by an empty FIFO
      if (ctrl.markReady)   payloadReady <= 1'b1;
      else if (fifoEmpty)   payloadReady <= 1'b0;

      if (ctrl.crcInit)          crcOk <= 1'b0;
      else if (ctrl.crcResValid) crcOk <= stat.crcMatch;
    end
  end

endmodule

// File: rtl/pkt_rx_ctrl.sv
module pkt_rx_ctrl
  import pkt_rx_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncFound,
  input  logic              rxValid,
  input  logic              cfgVarLen,
  input  logic [DATA_W-1:0] cfgPayloadLen,
  input  logic              cfgAddrEn,
  input  logic              cfgCrcEn,
  input  logic              cfgCrcAutoClearOff,
  input  dpStat_t           stat,
  output dpCtrl_t           ctrl
);

  rxState_t state, stateNext;
  logic     addrPending, addrPendingNext;
  logic     goTail;

  always_comb begin
    ctrl            = '0;
    stateNext       = state;
    addrPendingNext = addrPending;
    goTail          = 1'b0;

    unique case (state)
      ST_IDLE: begin
        if (syncFound) begin
          ctrl.crcInit = 1'b1;
          if (cfgVarLen) begin
            stateNext = ST_LEN;
          end else begin
            ctrl.cntLoadCfg = 1'b1;
            addrPendingNext = cfgAddrEn;
            if (cfgPayloadLen == '0) goTail = 1'b1;
            else                     stateNext = ST_BODY;
          end
        end
      end

      ST_LEN: begin
        if (rxValid) begin
          if (!stat.lenOk) begin
            ctrl.clrFifo = 1'b1;
            stateNext    = ST_IDLE;
          end else begin
            ctrl.wrByte      = 1'b1;
            ctrl.crcUpd      = 1'b1;
            ctrl.cntLoadByte = 1'b1;
            addrPendingNext  = cfgAddrEn;
            if (stat.byteZero) goTail = 1'b1;
            else               stateNext = ST_BODY;
          end
        end
      end

      ST_BODY: begin
        if (rxValid) begin
          if (addrPending && !stat.addrOk) begin
            ctrl.clrFifo = 1'b1;
            stateNext    = ST_IDLE;
          end else begin
            ctrl.wrByte     = 1'b1;
            ctrl.crcUpd     = 1'b1;
            ctrl.cntDec     = 1'b1;
            addrPendingNext = 1'b0;
            if (stat.cntOne) goTail = 1'b1;
          end
        end
      end

      ST_CRC_HI: begin
        if (rxValid) begin
          ctrl.capHi = 1'b1;
          stateNext  = ST_CRC_LO;
        end
      end

      ST_CRC_LO: begin
        if (rxValid) begin
          ctrl.crcResValid = 1'b1;
          if (stat.crcMatch || cfgCrcAutoClearOff) ctrl.markReady = 1'b1;
          else                                     ctrl.clrFifo   = 1'b1;
          stateNext = ST_IDLE;
        end
      end

      default: stateNext = ST_IDLE;
    endcase

    // end of body: either collect the CRC or finish here
    if (goTail) begin
      if (cfgCrcEn) begin
        stateNext = ST_CRC_HI;
      end else begin
        ctrl.markReady = 1'b1;
        stateNext      = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      addrPending <= 1'b0;
    end else begin
      state       <= stateNext;
      addrPending <= addrPendingNext;
    end
  end

endmodule

// File: rtl/pkt_rx_filter.sv
module pkt_rx_filter
  import pkt_rx_pkg::*;
#(
  parameter int          DATA_W   = BYTE_W,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_SEED = 16'h1D0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncFound,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              cfgVarLen,
  input  logic [DATA_W-1:0] cfgPayloadLen,
  input  logic              cfgAddrEn,
  input  logic [DATA_W-1:0] cfgNodeAddr,
  input  logic              cfgCrcEn,
  input  logic              cfgCrcAutoClearOff,
  input  logic              fifoEmpty,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] fifoWrData,
  output logic              fifoClear,
  output logic              payloadReady,
  output logic              crcOk
);

  dpCtrl_t ctrl;
  dpStat_t stat;

  pkt_rx_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk               (clk),
    .rstN              (rstN),
    .syncFound         (syncFound),
    .rxValid           (rxValid),
    .cfgVarLen         (cfgVarLen),
    .cfgPayloadLen     (cfgPayloadLen),
    .cfgAddrEn         (cfgAddrEn),
    .cfgCrcEn          (cfgCrcEn),
    .cfgCrcAutoClearOff(cfgCrcAutoClearOff),
    .stat              (stat),
    .ctrl              (ctrl)
  );

  pkt_rx_dp #(
    .DATA_W  (DATA_W),
    .CRC_POLY(CRC_POLY),
    .CRC_SEED(CRC_SEED)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .rxByte       (rxByte),
    .cfgPayloadLen(cfgPayloadLen),
    .cfgNodeAddr  (cfgNodeAddr),
    .fifoEmpty    (fifoEmpty),
    .stat         (stat),
    .fifoWrEn     (fifoWrEn),
    .fifoWrData   (fifoWrData),
    .fifoClear    (fifoClear),
    .payloadReady (payloadReady),
    .crcOk        (crcOk)
  );

endmodule

// File: rtl/pkt_rx_filter_chk.sv
module pkt_rx_filter_chk (
  input logic clk,
  input logic rstN,
  input logic rxValid,
  input logic fifoEmpty,
  input logic fifoWrEn,
  input logic fifoClear,
  input logic payloadReady,
  input logic crcOk
);

  // R2
  wr_needs_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> $past(rxValid));

  // R4
  wr_clr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoWrEn && fifoClear));

  // R7
  ready_not_on_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(payloadReady) |-> !fifoClear);

  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (payloadReady && !fifoEmpty) |=> payloadReady);

  // R6
  crc_ok_with_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(crcOk) |-> payloadReady);

endmodule

bind pkt_rx_filter pkt_rx_filter_chk uChk (.*);

// File: tb/tb_pkt_rx_filter.sv
module tb_pkt_rx_filter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       syncFound = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic       cfgVarLen = 1'b0;
  logic [7:0] cfgPayloadLen = '0;
  logic       cfgAddrEn = 1'b0;
  logic [7:0] cfgNodeAddr = 8'h3C;
  logic       cfgCrcEn = 1'b0;
  logic       cfgCrcAutoClearOff = 1'b0;
  logic       fifoEmpty = 1'b0;
  logic       fifoWrEn;
  logic [7:0] fifoWrData;
  logic       fifoClear;
  logic       payloadReady;
  logic       crcOk;

  int checks = 0;
  int errors = 0;
  logic [7:0] got[$];
  int clrSeen = 0;

  always #5 clk = ~clk;

  pkt_rx_filter dut (.*);

  // FIFO image built from the write port
  always @(negedge clk) begin
    if (rstN) begin
      if (fifoClear) begin
        got.delete();
        clrSeen++;
      end
      if (fifoWrEn) got.push_back(fifoWrData);
    end
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [15:0] benchCrc(input logic [7:0] q[$]);
    logic [15:0] c = 16'h1D0F;
    foreach (q[i]) begin
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[15] ^ q[i][b];
        c  = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  task automatic sendByte(input logic [7:0] b, input logic withSync, input int gap);
    @(negedge clk);
    rxValid   = 1'b1;
    rxByte    = b;
    syncFound = withSync;
    @(negedge clk);
    rxValid   = 1'b0;
    syncFound = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic pulseSync();
    @(negedge clk);
    syncFound = 1'b1;
    @(negedge clk);
    syncFound = 1'b0;
  endtask

  // one packet: build stream, predict outcome, drive, compare
  task automatic runPacket(input bit isVar, input int bodyLen, input int maxLen,
                           input bit addrEn, input bit addrGood, input bit crcEn,
                           input bit crcBad, input bit aco, input bit midSync,
                           input int gapMax);
    logic [7:0] body[$];
    logic [7:0] stream[$];
    logic [7:0] expWr[$];
    logic [15:0] crc;
    bit discard, reject, crcFail;
    bit expRdy, expOk, expClr;
    int mism;
    string tag;

    for (int i = 0; i < bodyLen; i++) body.push_back(8'($urandom_range(0, 255)));
    if (addrEn && bodyLen > 0) body[0] = addrGood ? cfgNodeAddr : (cfgNodeAddr ^ 8'h5A);

    cfgVarLen          = isVar;
    cfgPayloadLen      = isVar ? 8'(maxLen) : 8'(bodyLen);
    cfgAddrEn          = addrEn;
    cfgCrcEn           = crcEn;
    cfgCrcAutoClearOff = aco;

    if (isVar) stream.push_back(8'(bodyLen));
    foreach (body[i]) stream.push_back(body[i]);
    crc = benchCrc(stream) ^ (crcBad ? 16'h0001 : 16'h0000);

    discard = isVar && (bodyLen > maxLen);
    reject  = !discard && addrEn && bodyLen > 0 && !addrGood;
    crcFail = !discard && !reject && crcEn && crcBad;
    expClr  = discard || reject || (crcFail && !aco);
    expRdy  = !expClr;
    expOk   = expRdy && crcEn && !crcBad;
    if (!expClr) expWr = stream;

    if (discard)      tag = "R4";
    else if (reject)  tag = "R5";
    else if (crcFail) tag = aco ? "R8" : "R7";
    else if (crcEn)   tag = "R6";
    else              tag = isVar ? "R3" : "R2";
    if (midSync) tag = {tag, "/R10"};

    got.delete();
    clrSeen = 0;
    pulseSync();
    foreach (stream[i])
      sendByte(stream[i], midSync && (i == 1), $urandom_range(0, gapMax));
    if (crcEn) begin
      sendByte(crc[15:8], 1'b0, $urandom_range(0, gapMax));
      sendByte(crc[7:0], 1'b0, 0);
    end
    repeat (3) @(negedge clk);

    mism = (got.size() != expWr.size()) ? 1000 : 0;
    if (mism == 0) foreach (expWr[i]) if (got[i] !== expWr[i]) mism++;
    checkEq({tag, " fifo bytes mismatching"}, mism, 0);
    checkEq({tag, " fifo clear seen"}, (clrSeen > 0) ? 1 : 0, expClr ? 1 : 0);
    checkEq({tag, " payloadReady"}, int'(payloadReady), expRdy ? 1 : 0);
    checkEq({tag, " crcOk"}, int'(crcOk), expOk ? 1 : 0);

    // release of payloadReady by an empty FIFO
    @(negedge clk);
    fifoEmpty = 1'b1;
    @(negedge clk);
    fifoEmpty = 1'b0;
    if (expRdy) checkEq("R9 ready released by fifoEmpty", int'(payloadReady), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20231));
    repeat (3) @(negedge clk);
    checkEq("R1 fifoWrEn in reset", int'(fifoWrEn), 0);
    checkEq("R1 payloadReady in reset", int'(payloadReady), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 fifoClear after reset", int'(fifoClear), 0);
    checkEq("R1 crcOk after reset", int'(crcOk), 0);

    // directed corners
    runPacket(0, 4, 0, 0, 0, 0, 0, 0, 0, 2);   // R2 fixed
    runPacket(1, 5, 5, 0, 0, 0, 0, 0, 0, 1);   // R3 length equals maximum
    runPacket(1, 0, 3, 0, 0, 0, 0, 0, 0, 0);   // R3 zero length
    runPacket(1, 6, 5, 0, 0, 0, 0, 0, 0, 0);   // R4 length one above maximum
    runPacket(0, 3, 0, 1, 0, 0, 0, 0, 0, 0);   // R5 fixed address miss
    runPacket(1, 3, 8, 1, 0, 1, 0, 0, 0, 0);   // R5 variable address miss
    runPacket(1, 4, 8, 1, 1, 1, 0, 0, 0, 1);   // R5 address hit, R6 good CRC
    runPacket(0, 5, 0, 0, 0, 1, 1, 0, 0, 0);   // R7 bad CRC flushed
    runPacket(0, 5, 0, 0, 0, 1, 1, 1, 0, 0);   // R8 bad CRC kept
    runPacket(0, 0, 0, 1, 0, 1, 0, 0, 0, 0);   // R6 empty fixed body with CRC
    runPacket(0, 6, 0, 0, 0, 1, 0, 0, 1, 0);   // R10 sync mid-packet

    // R9 collision: completion and fifoEmpty on the same edge
    cfgVarLen = 1'b0; cfgPayloadLen = 8'd2; cfgAddrEn = 1'b0; cfgCrcEn = 1'b0;
    fifoEmpty = 1'b1;
    pulseSync();
    sendByte(8'hA1, 1'b0, 0);
    @(negedge clk);
    rxValid = 1'b1; rxByte = 8'hB2;
    @(negedge clk);
    rxValid = 1'b0;
    checkEq("R9 set wins over fifoEmpty", int'(payloadReady), 1);
    @(negedge clk);
    checkEq("R9 cleared next cycle", int'(payloadReady), 0);
    fifoEmpty = 1'b0;

    // constrained random packets
    for (int n = 0; n < 60; n++) begin
      bit isVar, disc;
      int len, mx;
      isVar = 1'($urandom_range(0, 1));
      len   = $urandom_range(0, 12);
      disc  = isVar && (len > 0) && ($urandom_range(0, 4) == 0);
      mx    = disc ? len - 1 : len + $urandom_range(0, 3);
      runPacket(isVar, len, mx, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0),
                1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
                1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0), 2);
    end

    finishRun();
  end

endmodule